// File: doc/BRIEF.md
# Flash Word-Program Command Controller

This block is the command front end of a behavioural NOR-style flash model. A host issues single-cycle write strobes (`we`) with an address and a data word. The low byte of the data word carries the command code. The host issues single-cycle read strobes (`re`) to fetch either array contents or a status byte. A word program is a two-write sequence: first a setup command, then a write that carries the target address and the data. Each block has a lock bit and a lock-down bit. A write-protect input decides whether a locked-down block may be unlocked. A modelled busy period follows each accepted program. The status byte reports that busy period and any errors.

The array is a small register file of `NUM_BLOCKS` blocks of `WORDS_PER_BLOCK` words, erased to all ones at reset. Programming can only clear bits. Blocks are grouped into programming regions of `BLOCKS_PER_REGION` blocks. The region of the most recent program target is presented on an output.

State machine `fwp_ctrl` has these states:
- `ST_IDLE` decodes commands. It moves to `ST_PGM_SETUP` on 40h or 10h and to `ST_LCK_SETUP` on 60h. It stays in `ST_IDLE` on every other code.
- `ST_PGM_SETUP` takes the next write as the address and data. It moves to `ST_BUSY` when the target block is unlocked. It returns to `ST_IDLE` with errors when the block is locked.
- `ST_LCK_SETUP` applies the next write as a lock operation and returns to `ST_IDLE`.
- `ST_BUSY` waits `BUSY_CYCLES` cycles. It commits the word and returns to `ST_IDLE`.

Top module: `fwp_ctrl`

## Requirements

Status byte layout, returned on the low byte of `rdata` with the upper bits zero:
- bit 7: ready
- bit 5: command error
- bit 4: program error
- bit 1: block-locked error
- all other bits: 0

- R1: After reset every array word reads FFFFh, reads return array data, every block is locked, no block is locked down, all error bits are 0 and `region_idx` is 0.
- R2: A write of 40h or 10h in idle, followed by one write with address and data, programs that word. From the setup write onward, reads return the status byte.
- R3: Status bit 7 reads 0 for `BUSY_CYCLES` cycles after an accepted program data write, then reads 1 again. In the idle state bit 7 reads 1.
- R4: A program stores (old AND data). If the data has a 1 where the old word has a 0, that cell stays 0 and status bit 4 is set once the busy period ends.
- R5: A program data write to a locked block sets status bits 4 and 1, leaves the array unchanged and has no busy period.
- R6: The sequence 60h and then 01h locks the block of the second write's address. The sequence 60h and then 2Fh locks the block and locks it down. The sequence 60h and then D0h unlocks the block.
- R7: An unlock of a locked-down block is refused while `wp_on` is 1 and accepted while it is 0. The lock-down bit stays set until reset.
- R8: E8h, 80h or D0h written in idle, or a second lock-setup byte other than 01h, D0h or 2Fh, sets status bit 5. Reads then return status.
- R9: Error bits stay set until a 50h write in idle clears bits 5, 4 and 1. A FFh write in idle makes reads return array data.
- R10: Each program data write sets `region_idx` to (target block / `BLOCKS_PER_REGION`). No other write changes it.
- R11: Writes that arrive during the busy period are ignored.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_on | input | 1 | Write protect: 1 forbids unlocking locked-down blocks |
| we | input | 1 | Write strobe, one cycle per bus write |
| re | input | 1 | Read strobe, result on `rdata` after the next edge |
| addr | input | ADDR_W | Word address: block index in the upper bits |
| wdata | input | DATA_W | Write data; the command code is in bits 7:0 |
| rdata | output | DATA_W | Registered read result: array word or status byte |
| region_idx | output | RGN_W | Programming region of the last program target |

## Verification

The hardest condition to reach from the ports is a locked-down block whose lock bit has been cleared. The stimulus reaches it as follows:
1. Lock the block down.
2. Attempt an unlock with `wp_on` high and confirm it is refused.
3. Drop `wp_on`, unlock, and confirm a program succeeds.
4. Re-lock the block, raise `wp_on` again, and show the unlock is still refused.

This last step proves the lock-down bit outlived the unlock. A final reset then shows that the protected unlock is accepted. Writes during the short busy window are timed from the data write so that they land while status bit 7 is still 0.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PGM_SETUP,
        ST_LCK_SETUP,
        ST_BUSY
    } st_e;

    typedef enum logic [1:0] {
        LK_NONE,
        LK_SET,
        LK_CLR,
        LK_DOWN
    } lk_op_e;

    localparam logic [7:0] CMD_PGM_A    = 8'h40;
    localparam logic [7:0] CMD_PGM_B    = 8'h10;
    localparam logic [7:0] CMD_BUF      = 8'hE8;
    localparam logic [7:0] CMD_EFP      = 8'h80;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
    localparam logic [7:0] CMD_CLR_ST   = 8'h50;
    localparam logic [7:0] CMD_RD_ARR   = 8'hFF;
    localparam logic [7:0] CMD_LCK      = 8'h60;
    localparam logic [7:0] CMD_LCK_SET  = 8'h01;
    localparam logic [7:0] CMD_LCK_DOWN = 8'h2F;

endpackage

// File: rtl/fwp_lock.sv
module fwp_lock
    import fwp_pkg::*;
#(
    parameter int NUM_BLOCKS = 32,
    localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] blk,
    input  lk_op_e           op,
    input  logic             wp_on,
    output logic             locked
);

    logic [NUM_BLOCKS-1:0] lk_q;
    logic [NUM_BLOCKS-1:0] ld_q;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lk_q[b] <= 1'b1;
                ld_q[b] <= 1'b0;
            end else if (blk == BLK_W'(b)) begin
                unique case (op)
                    LK_SET:  lk_q[b] <= 1'b1;
                    LK_DOWN: begin
                        lk_q[b] <= 1'b1;
                        ld_q[b] <= 1'b1;
                    end
                    LK_CLR:  if (!(ld_q[b] && wp_on)) lk_q[b] <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    assign locked = lk_q[blk];

endmodule

// File: rtl/fwp_array.sv
module fwp_array #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b
);

    logic [DATA_W-1:0] cell_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q[w] <= '1;
            end else if (wr_en && wr_addr == ADDR_W'(w)) begin
                cell_q[w] <= wr_data;
            end
        end
    end

    assign rd_data_a = cell_q[rd_addr_a];
    assign rd_data_b = cell_q[rd_addr_b];

endmodule

// File: rtl/fwp_busy_timer.sv
module fwp_busy_timer #(
    parameter int CYCLES = 4,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/fwp_ctrl.sv
module fwp_ctrl
    import fwp_pkg::*;
#(
    parameter int DATA_W            = 16,
    parameter int NUM_BLOCKS        = 32,
    parameter int WORDS_PER_BLOCK   = 2,
    parameter int BLOCKS_PER_REGION = 8,
    parameter int BUSY_CYCLES       = 4,
    localparam int DEPTH  = NUM_BLOCKS * WORDS_PER_BLOCK,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int WRD_W  = $clog2(WORDS_PER_BLOCK),
    localparam int BLK_W  = $clog2(NUM_BLOCKS),
    localparam int NRGN   = NUM_BLOCKS / BLOCKS_PER_REGION,
    localparam int RGN_W  = (NRGN > 1) ? $clog2(NRGN) : 1,
    localparam int RGN_SH = $clog2(BLOCKS_PER_REGION)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_on,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [RGN_W-1:0]  region_idx
);

    st_e               state, state_n;
    logic              rmode_stat;
    logic              err_cmd, err_prog, err_lock;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;
    logic [RGN_W-1:0]  region_q;

    logic [BLK_W-1:0]  blk;
    logic              blk_locked;
    lk_op_e            lk_op;
    logic [7:0]        cmd;
    logic [DATA_W-1:0] arr_rd, arr_old;
    logic              tmr_start, tmr_busy, tmr_done;
    logic              commit;
    logic [7:0]        status;

    assign cmd = wdata[7:0];
    assign blk = addr[ADDR_W-1:WRD_W];

    fwp_lock #(.NUM_BLOCKS(NUM_BLOCKS)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .blk    (blk),
        .op     (lk_op),
        .wp_on  (wp_on),
        .locked (blk_locked)
    );

    fwp_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (commit),
        .wr_addr   (pend_addr),
        .wr_data   (arr_old & pend_data),
        .rd_addr_a (addr),
        .rd_data_a (arr_rd),
        .rd_addr_b (pend_addr),
        .rd_data_b (arr_old)
    );

    fwp_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next state and decode strobes
    always_comb begin
        state_n   = state;
        lk_op     = LK_NONE;
        tmr_start = 1'b0;
        commit    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (we) begin
                    if (cmd == CMD_PGM_A || cmd == CMD_PGM_B) state_n = ST_PGM_SETUP;
                    else if (cmd == CMD_LCK)                  state_n = ST_LCK_SETUP;
                end
            end
            ST_PGM_SETUP: begin
                if (we) begin
                    if (blk_locked) begin
                        state_n = ST_IDLE;
                    end else begin
                        state_n   = ST_BUSY;
                        tmr_start = 1'b1;
                    end
                end
            end
            ST_LCK_SETUP: begin
                if (we) begin
                    state_n = ST_IDLE;
                    if (cmd == CMD_LCK_SET)       lk_op = LK_SET;
                    else if (cmd == CMD_CONFIRM)  lk_op = LK_CLR;
                    else if (cmd == CMD_LCK_DOWN) lk_op = LK_DOWN;
                end
            end
            ST_BUSY: begin
                if (tmr_done || !tmr_busy) begin
                    state_n = ST_IDLE;
                    commit  = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign status = {(state != ST_BUSY), 1'b0, err_cmd, err_prog, 2'b00, err_lock, 1'b0};

    // Output and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rmode_stat <= 1'b0;
            err_cmd    <= 1'b0;
            err_prog   <= 1'b0;
            err_lock   <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
            region_q   <= '0;
            rdata      <= '0;
        end else begin
            if (re) rdata <= rmode_stat ? DATA_W'(status) : arr_rd;
            unique case (state)
                ST_IDLE: begin
                    if (we) begin
                        if (cmd == CMD_PGM_A || cmd == CMD_PGM_B || cmd == CMD_LCK) begin
                            rmode_stat <= 1'b1;
                        end else if (cmd == CMD_BUF || cmd == CMD_EFP || cmd == CMD_CONFIRM) begin
                            rmode_stat <= 1'b1;
                            err_cmd    <= 1'b1;
                        end else if (cmd == CMD_CLR_ST) begin
                            err_cmd  <= 1'b0;
                            err_prog <= 1'b0;
                            err_lock <= 1'b0;
                        end else if (cmd == CMD_RD_ARR) begin
                            rmode_stat <= 1'b0;
                        end
                    end
                end
                ST_PGM_SETUP: begin
                    if (we) begin
                        region_q <= RGN_W'(blk >> RGN_SH);
                        if (blk_locked) begin
                            err_prog <= 1'b1;
                            err_lock <= 1'b1;
                        end else begin
                            pend_addr <= addr;
                            pend_data <= wdata;
                        end
                    end
                end
                ST_LCK_SETUP: begin
                    if (we && !(cmd == CMD_LCK_SET || cmd == CMD_CONFIRM || cmd == CMD_LCK_DOWN)) begin
                        err_cmd <= 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (commit && ((pend_data & ~arr_old) != '0)) err_prog <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign region_idx = region_q;

endmodule

// File: rtl/fwp_ctrl_chk.sv
module fwp_ctrl_chk
    import fwp_pkg::*;
#(
    parameter int BUSY_CYCLES = 4,
    parameter int RGN_W       = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             we,
    input logic [7:0]       cmd,
    input st_e              state,
    input logic             err_cmd,
    input logic             err_prog,
    input logic             err_lock,
    input logic [RGN_W-1:0] region_idx
);

    int busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)                busy_run <= 0;
        else if (state == ST_BUSY) busy_run <= busy_run + 1;
        else                       busy_run <= 0;
    end

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= BUSY_CYCLES);

    // R5
    lock_err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_lock) |-> err_prog);

    // R9
    clear_st_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && we && cmd == CMD_CLR_ST) |=> (!err_cmd && !err_prog && !err_lock));

    // R9
    sticky_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_prog && !(state == ST_IDLE && we && cmd == CMD_CLR_ST)) |=> err_prog);

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && we) |=> ($stable(err_cmd) && $stable(err_lock)));

    // R10
    region_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_PGM_SETUP && we) |=> $stable(region_idx));

endmodule

bind fwp_ctrl fwp_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES), .RGN_W(RGN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (we),
    .cmd        (wdata[7:0]),
    .state      (state),
    .err_cmd    (err_cmd),
    .err_prog   (err_prog),
    .err_lock   (err_lock),
    .region_idx (region_idx)
);

// File: tb/fwp_ctrl_bench.sv
module fwp_ctrl_bench;

    localparam int DW = 16;
    localparam int AW = 6;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_on = 1'b0;
    logic          we = 1'b0;
    logic          re = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [RW-1:0] region_idx;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    logic          rd_pend = 1'b0;

    always #5 clk = ~clk;

    fwp_ctrl u_fwp_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wp_on      (wp_on),
        .we         (we),
        .re         (re),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .region_idx (region_idx)
    );

    // Monitor: compares each read result with the queued expectation
    always @(posedge clk) rd_pend <= re;

    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string         t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        @(negedge clk);
        addr = a;
        re   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_rgn(input logic [RW-1:0] e, input string t);
        checks++;
        if (region_idx !== e) begin
            errors++;
            $display("FAIL %s: region_idx actual %0d expected %0d", t, region_idx, e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: erased array, array read mode, region 0
        rd(6'd5, 16'hFFFF, "R1 erased word");
        chk_rgn(2'd0, "R1 region after reset");

        // R5 / R10: program to block 10 (locked at reset), region 1
        wr(6'd20, 16'h0040);
        rd(6'd20, 16'h0080, "R2 status after setup");
        wr(6'd20, 16'h1234);
        chk_rgn(2'd1, "R10 region block 10");
        rd(6'd20, 16'h0092, "R5 locked program errors");
        wr(6'd0, 16'h0050);
        rd(6'd20, 16'h0080, "R9 clear status");
        wr(6'd0, 16'h00FF);
        rd(6'd20, 16'hFFFF, "R5 array unchanged");

        // R6 unlock then R2/R3 program
        wr(6'd20, 16'h0060);
        wr(6'd20, 16'h00D0);
        wr(6'd20, 16'h0010);
        wr(6'd20, 16'hA5F0);
        rd(6'd20, 16'h0000, "R3 busy reads not ready");
        idle(8);
        rd(6'd20, 16'h0080, "R3 ready after busy");
        wr(6'd0, 16'h00FF);
        rd(6'd20, 16'hA5F0, "R2 programmed word");

        // R4 AND behaviour with 0->1 attempt
        wr(6'd20, 16'h0040);
        wr(6'd20, 16'h0FFF);
        idle(8);
        rd(6'd20, 16'h0090, "R4 set-bit attempt error");
        wr(6'd0, 16'h00FF);
        rd(6'd20, 16'h05F0, "R4 cells only cleared");
        wr(6'd0, 16'h0050);
        wr(6'd20, 16'h0040);
        wr(6'd20, 16'h0100);
        idle(8);
        rd(6'd20, 16'h0080, "R4 clean program no error");

        // R11 write during busy is ignored
        wr(6'd21, 16'h0040);
        wr(6'd21, 16'hFFFE);
        wr(6'd0, 16'h00FF);
        idle(8);
        rd(6'd21, 16'h0080, "R11 busy write ignored");
        wr(6'd0, 16'h00FF);
        rd(6'd21, 16'hFFFE, "R11 programmed word");

        // R8 unsupported commands
        wr(6'd0, 16'h00E8);
        rd(6'd0, 16'h00A0, "R8 E8h command error");
        wr(6'd0, 16'h0050);
        wr(6'd0, 16'h0080);
        rd(6'd0, 16'h00A0, "R8 80h command error");
        wr(6'd0, 16'h0050);
        wr(6'd0, 16'h00D0);
        rd(6'd0, 16'h00A0, "R8 D0h command error");
        wr(6'd0, 16'h0050);
        wr(6'd0, 16'h0060);
        wr(6'd0, 16'h0055);
        rd(6'd0, 16'h00A0, "R8 bad lock byte");
        wr(6'd0, 16'h0050);

        // R6 lock
        wr(6'd20, 16'h0060);
        wr(6'd20, 16'h0001);
        wr(6'd20, 16'h0040);
        wr(6'd20, 16'h0000);
        rd(6'd20, 16'h0092, "R6 lock refuses program");
        wr(6'd0, 16'h0050);

        // R7 lock-down with write protect
        wr(6'd20, 16'h0060);
        wr(6'd20, 16'h002F);
        wp_on = 1'b1;
        wr(6'd20, 16'h0060);
        wr(6'd20, 16'h00D0);
        wr(6'd20, 16'h0040);
        wr(6'd20, 16'h0000);
        rd(6'd20, 16'h0092, "R7 protected unlock refused");
        wr(6'd0, 16'h0050);
        wp_on = 1'b0;
        wr(6'd20, 16'h0060);
        wr(6'd20, 16'h00D0);
        wr(6'd20, 16'h0040);
        wr(6'd20, 16'h0000);
        idle(8);
        rd(6'd20, 16'h0080, "R7 unprotected unlock accepted");
        wr(6'd0, 16'h00FF);
        rd(6'd20, 16'h0000, "R7 word programmed");
        wr(6'd20, 16'h0060);
        wr(6'd20, 16'h0001);
        wp_on = 1'b1;
        wr(6'd20, 16'h0060);
        wr(6'd20, 16'h00D0);
        wr(6'd20, 16'h0040);
        wr(6'd20, 16'h0000);
        rd(6'd20, 16'h0092, "R7 lock-down persists");
        wr(6'd0, 16'h0050);

        // R10 region of block 31, unchanged by other writes
        wr(6'd62, 16'h0040);
        wr(6'd62, 16'h0000);
        chk_rgn(2'd3, "R10 region block 31");
        wr(6'd0, 16'h0050);
        wr(6'd2, 16'h00FF);
        chk_rgn(2'd3, "R10 region held");

        // R1 / R7 reset clears lock-down; wp still high
        do_reset();
        rd(6'd20, 16'hFFFF, "R1 array erased by reset");
        wr(6'd20, 16'h0060);
        wr(6'd20, 16'h00D0);
        wr(6'd20, 16'h0040);
        wr(6'd20, 16'h1111);
        idle(8);
        rd(6'd20, 16'h0080, "R7 reset cleared lock-down");

        idle(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule